// File: doc/BRIEF.md
# Dual-Rail Overcurrent Fault Latch

This block decides when a short on one of the three switched standby rails is real. Each rail has a digital flag that says the rail's output is below its trip level, which sits near half of nominal. It also has a monitor-enable flag from the power sequencer that says whether the rail is switched on at the moment. A rail that is monitored and stays low runs its own qualification timer. This lets capacitor inrush at power-up and brief overloads pass without a fault.

When any timer reaches the trip time, the block sets one global fault flag. The power-state logic uses this flag to switch off every output, not only the faulted one. At the same moment a cause vector records which rails had timed out. The fault and its cause then hold until the board cycles the enable input low and high again, or drops the standby supply-good flag. The low-voltage and 3.3 V auxiliary regulators are not wired into this block, so they are never watched.

The default trip time is 2,500,000 cycles, which is 50 ms at a 50 MHz clock. This sits inside the required window of 1 ms to 75 ms.

Top module: `ocp_fault_latch`

## Requirements
- R1: While reset is asserted and right after it, `fault_latched` is 0 and `fault_cause` is 0.
- R2: The timer of a rail counts each clock edge at which that rail's `rail_low` and `rail_watch` bits are both 1, while `enable` and `supply_ok` are high and no fault is latched. On the `TRIP_CYCLES`-th consecutive such edge, `fault_latched` becomes 1. At that edge, bit i of `fault_cause` is set for every rail i whose timer expired. The bit map is: bit 0 memory rail, bit 1 3.3 V rail, bit 2 5 V rail.
- R3: If a rail returns above its trip level before `TRIP_CYCLES` qualifying edges, no fault is latched. Its timer restarts from zero, so a later low period again needs a full `TRIP_CYCLES` edges.
- R4: A rail whose `rail_watch` bit is 0 is not monitored. Its `rail_low` flag has no effect and its timer is held at zero.
- R5: `fault_cause` holds only the rails that expired on the latching edge. A rail that would expire later, while the fault is held, is not added.
- R6: Once set, `fault_latched` and `fault_cause` stay unchanged when the rails recover and when `enable` is low. Only the clears of R7 and R8 change them.
- R7: A low-to-high change of `enable` is seen at the first clock edge that samples `enable` high. The fault and cause clear at the next edge. While `enable` is low, all timers are held at zero.
- R8: When `supply_ok` is sampled low, the fault and cause clear at that edge and all timers are held at zero.
- R9: While a fault is latched, all timers are held at zero. After a clear, a rail that is still low needs a full `TRIP_CYCLES` qualifying edges before the fault latches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rail_low | input | NUM_RAILS | Per-rail flag: output is below its trip level |
| rail_watch | input | NUM_RAILS | Per-rail monitor enable from the sequencer |
| enable | input | 1 | Block enable; a low-then-high toggle clears the fault |
| supply_ok | input | 1 | Standby supply above its undervoltage level |
| fault_latched | output | 1 | Global fault; all outputs must be off while high |
| fault_cause | output | NUM_RAILS | Rails whose timers expired at latching |

## Verification
Each result appears a fixed number of edges after its stimulus.
- A sustained low rail latches the fault after exactly `TRIP_CYCLES` edges, and the bench also checks one edge earlier to see the fault still clear.
- A `supply_ok` drop clears the fault after one edge.
- An `enable` rise clears it after two edges, and the bench checks the edge in between to see the fault still held.
- A re-trip after a clear needs two more edges than the trip time, because of the held timer.

The bench drives inputs on the falling edge and samples on a later falling edge. In this way every check counts whole rising edges from its stimulus.

// File: rtl/ocp_fault_pkg.sv
package ocp_fault_pkg;
    // rail positions inside the cause vector
    localparam int unsigned RAIL_MEM   = 0;
    localparam int unsigned RAIL_3V3   = 1;
    localparam int unsigned RAIL_5V    = 2;
    localparam int unsigned RAIL_COUNT = 3;

    // 50 ms at 50 MHz
    localparam int unsigned DEFAULT_TRIP = 2_500_000;
endpackage

// File: rtl/ocp_rail_timer.sv
module ocp_rail_timer #(
    parameter int unsigned TRIP_CYCLES = ocp_fault_pkg::DEFAULT_TRIP,
    localparam int unsigned CNT_W = $clog2(TRIP_CYCLES) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic below,
    input  logic watch,
    input  logic hold,
    output logic expire
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TRIP_CYCLES - 1);

    logic             qualify;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        qualify = below && watch && !hold;
        expire  = qualify && (cnt_q == LAST);
        if (!qualify)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // a rail that is not qualifying restarts from zero
    assert_timer_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !qualify |=> (cnt_q == '0));

    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // held or unwatched rails never expire
    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!watch || hold) |-> !expire);
endmodule

// File: rtl/ocp_clear_ctrl.sv
module ocp_clear_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic clr
);
    typedef struct packed {
        logic en_seen;
        logic clr;
    } clr_state_t;

    clr_state_t st_d, st_q;

    always_comb begin
        st_d.en_seen = enable;
        st_d.clr     = enable && !st_q.en_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clr = st_q.clr;

    // a clear pulse is one cycle wide
    assert_clear_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !clr);
endmodule

// File: rtl/ocp_fault_latch.sv
module ocp_fault_latch #(
    parameter int unsigned NUM_RAILS   = ocp_fault_pkg::RAIL_COUNT,
    parameter int unsigned TRIP_CYCLES = ocp_fault_pkg::DEFAULT_TRIP
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] rail_low,
    input  logic [NUM_RAILS-1:0] rail_watch,
    input  logic                 enable,
    input  logic                 supply_ok,
    output logic                 fault_latched,
    output logic [NUM_RAILS-1:0] fault_cause
);
    typedef struct packed {
        logic                 fault;
        logic [NUM_RAILS-1:0] cause;
    } latch_state_t;

    latch_state_t         st_d, st_q;
    logic [NUM_RAILS-1:0] expire;
    logic                 hold;
    logic                 clr;

    assign hold = st_q.fault || !enable || !supply_ok;

    for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
        ocp_rail_timer #(.TRIP_CYCLES(TRIP_CYCLES)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .below (rail_low[i]),
            .watch (rail_watch[i]),
            .hold  (hold),
            .expire(expire[i])
        );
    end

    ocp_clear_ctrl u_clear (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .clr   (clr)
    );

    always_comb begin
        st_d = st_q;
        if (!supply_ok || clr) begin
            st_d = '0;
        end else if (!st_q.fault && (expire != '0)) begin
            st_d.fault = 1'b1;
            st_d.cause = expire;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fault_latched = st_q.fault;
    assign fault_cause   = st_q.cause;

    assert_latch_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fault && supply_ok && !clr) |=> (st_q.fault && $stable(st_q.cause)));

    assert_supply_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!st_q.fault && st_q.cause == '0));

    assert_enable_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.fault);

    assert_cause_present_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |-> (st_q.cause != '0));

    assert_no_expire_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fault |-> (expire == '0));
endmodule

// File: tb/ocp_fault_latch_test.sv
module ocp_fault_latch_test;
    localparam int unsigned NR   = 3;
    localparam int unsigned TRIP = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rail_low = '0;
    logic [NR-1:0] rail_watch = '0;
    logic          enable = 1'b1;
    logic          supply_ok = 1'b1;
    logic          fault_latched;
    logic [NR-1:0] fault_cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ocp_fault_latch #(.NUM_RAILS(NR), .TRIP_CYCLES(TRIP)) uut (
        .clk(clk), .rst_n(rst_n), .rail_low(rail_low), .rail_watch(rail_watch),
        .enable(enable), .supply_ok(supply_ok),
        .fault_latched(fault_latched), .fault_cause(fault_cause)
    );

    typedef struct packed {
        logic [NR-1:0] low;
        logic [NR-1:0] watch;
        logic [7:0]    edges;
        logic          exp_fault;
        logic [NR-1:0] exp_cause;
    } vec_t;

    // bit0 memory, bit1 3.3 V, bit2 5 V
    localparam vec_t VECS [8] = '{
        '{3'b001, 3'b111, 8'd7,  1'b0, 3'b000},  // R3 one edge short
        '{3'b001, 3'b111, 8'd8,  1'b1, 3'b001},  // R2 memory rail
        '{3'b110, 3'b111, 8'd8,  1'b1, 3'b110},  // R2 two rails at once
        '{3'b111, 3'b000, 8'd20, 1'b0, 3'b000},  // R4 all unwatched
        '{3'b100, 3'b011, 8'd20, 1'b0, 3'b000},  // R4 low rail unwatched
        '{3'b010, 3'b010, 8'd8,  1'b1, 3'b010},  // R2 3.3 V rail
        '{3'b111, 3'b101, 8'd8,  1'b1, 3'b101},  // R4 masked bit absent
        '{3'b000, 3'b111, 8'd30, 1'b0, 3'b000}   // R2 no low rails
    };

    task automatic edges(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic ef, input logic [NR-1:0] ec);
        checks++;
        if (fault_latched !== ef || fault_cause !== ec) begin
            errors++;
            $display("FAIL %s: fault=%b cause=%b expected fault=%b cause=%b",
                     req, fault_latched, fault_cause, ef, ec);
        end
    endtask

    task automatic supply_clear();
        rail_low  = '0;
        supply_ok = 1'b0;
        edges(1);
        supply_ok = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        edges(2);
        check("R1 in reset", 1'b0, 3'b000);
        rst_n = 1'b1;
        edges(3);
        check("R1 after reset", 1'b0, 3'b000);

        for (int i = 0; i < 8; i++) begin
            supply_clear();
            rail_watch = VECS[i].watch;
            rail_low   = VECS[i].low;
            edges(int'(VECS[i].edges));
            checks++;
            if (fault_latched !== VECS[i].exp_fault || fault_cause !== VECS[i].exp_cause) begin
                errors++;
                $display("FAIL R2/R3/R4 row %0d: fault=%b cause=%b expected fault=%b cause=%b",
                         i, fault_latched, fault_cause, VECS[i].exp_fault, VECS[i].exp_cause);
            end
        end

        // R3: recovery restarts the timer
        supply_clear();
        rail_watch = 3'b111;
        rail_low = 3'b100; edges(5);
        rail_low = 3'b000; edges(1);
        rail_low = 3'b100; edges(7);
        check("R3 restart after recovery", 1'b0, 3'b000);
        edges(1);
        check("R3 full period trips", 1'b1, 3'b100);

        // R5/R6: later rail not added, fault holds after recovery
        supply_clear();
        rail_low = 3'b001; edges(3);
        rail_low = 3'b101; edges(5);
        check("R5 first rail only", 1'b1, 3'b001);
        edges(10);
        check("R5 later rail not added", 1'b1, 3'b001);
        rail_low = 3'b000; edges(6);
        check("R6 holds after recovery", 1'b1, 3'b001);

        // R7: enable toggle, low phase holds the fault
        enable = 1'b0; edges(3);
        check("R6 holds while enable low", 1'b1, 3'b001);
        enable = 1'b1; edges(1);
        check("R7 detect edge, still held", 1'b1, 3'b001);
        edges(1);
        check("R7 cleared after toggle", 1'b0, 3'b000);

        // R7: timers held while enable low
        enable = 1'b0; rail_low = 3'b111; edges(20);
        check("R7 no monitoring while disabled", 1'b0, 3'b000);
        rail_low = 3'b000; enable = 1'b1; edges(3);

        // R8: supply drop clears
        rail_low = 3'b010; edges(8);
        check("R8 setup trip", 1'b1, 3'b010);
        supply_ok = 1'b0; edges(1);
        check("R8 supply drop clears", 1'b0, 3'b000);
        edges(10);
        check("R8 timers held while supply low", 1'b0, 3'b000);
        supply_ok = 1'b1;
        rail_low = 3'b000; edges(2);

        // R9: rail stays low across a clear
        rail_low = 3'b001; edges(8);
        check("R9 setup trip", 1'b1, 3'b001);
        enable = 1'b0; edges(2);
        enable = 1'b1; edges(9);
        check("R9 one edge before re-trip", 1'b0, 3'b000);
        edges(1);
        check("R9 re-trip after full period", 1'b1, 3'b001);

        finish_run();
    end
endmodule